// File: doc/BRIEF.md
# Capacitor Group Switching Controller

This block chooses which of six shunt capacitor groups should be connected to cancel the reactive power drawn by a load. Each time a new signed reactive-power sample arrives with its valid strobe, the block compares it against a switch-in and a switch-out threshold. Both thresholds are derived from a set-point percentage and the stored power of group 1. When the load is inductive enough, one disconnected group is connected. When it is capacitive enough, one connected group is released. In both cases the group whose stored power best matches the present reactive power is the one chosen, so groups are used in whatever order fits the load rather than in a fixed rotation.

After each switching action the block waits for a programmable number of prescaled ticks before it acts again. A per-group enable mask removes groups from service: a masked group is never connected, and if it is connected it is dropped at once. When an action is required but no group is eligible, the contactor state is kept and a saturation flag reports it.

Top module: `capbank_switch_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the contactor vector and the saturation flag are all zero.
- R2: For sample Q, set point x (percent) and group-1 power q1, connection is required when Q > 0 and 100·Q > (60 + x)·q1. Release is required when Q < 0 and 100·Q < (x − 60)·q1. Equality with a threshold is not enough.
- R3: A sample that requires neither action leaves the contactor vector unchanged, apart from forced releases.
- R4: On a connection, the group chosen is the disconnected, enabled group with the smallest |Q − q(n)|. Ties go to the lowest group number. Bit n−1 of the contactor vector and slice n−1 of the group power bus belong to group n.
- R5: On a release, the group chosen is the connected, enabled group with the smallest ||Q| − q(n)|. Ties go to the lowest group number.
- R6: One evaluation changes at most one enabled group.
- R7: After a switching action at a clock edge, samples are ignored until HOLD·TICK_DIV further edges have passed. HOLD is the delay setting captured at that action. The first edge allowed to act again is edge HOLD·TICK_DIV + 1.
- R8: A group whose enable bit is 0 is never connected. If it is connected, it is cleared at the next clock edge, whether or not a sample is valid. This forced release does not restart the wait.
- R9: When an evaluated sample requires an action and no group is eligible, the contactor vector keeps its value and the saturation flag is set. Any other evaluated sample clears the flag. Samples that are not evaluated leave it unchanged.
- R10: A sample is evaluated only on an edge where the valid strobe is 1 and the wait of R7 has expired. Its result appears on the outputs after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qValid | input | 1 | Strobe: qMeas holds a new sample |
| qMeas | input | Q_W | Signed load reactive power; positive is inductive |
| groupKvar | input | NUM_GROUPS·QG_W | Unsigned stored power of each group, group 1 in the low slice |
| setPct | input | PCT_W | Set point x in percent |
| holdTicks | input | DLY_W | Wait between actions in prescaled ticks |
| groupEn | input | NUM_GROUPS | Per-group service enable |
| contactor | output | NUM_GROUPS | Contactor drive, bit 0 is group 1 |
| satFlag | output | 1 | Required action had no eligible group |

## Verification
The bench targets samples that sit exactly on each threshold. A design that compares with the wrong sign of inequality, or that drops the factor of 100, would switch there. It also targets ties in the fit, where a design that keeps the last best candidate instead of the first would pick a higher group. The edge that ends the wait is probed one cycle early and one cycle exactly, which catches off-by-one errors in the prescaler or the hold counter. Other targets are a group disabled while it is connected, and saturation being set and then cleared. A model that tracks each clock edge compares every cycle of a long random run, so a design that switched two groups at once or acted on a non-valid cycle would show a mismatch.

// File: rtl/capbank_pkg.sv
package capbank_pkg;

  // Strobes from the control to the datapath for one evaluation edge
  typedef struct packed {
    logic switchIn;
    logic switchOut;
    logic setSat;
    logic clrSat;
  } capStrobe_t;

  // Decision inputs from the datapath to the control
  typedef struct packed {
    logic wantIn;
    logic wantOut;
    logic haveIn;
    logic haveOut;
  } capStatus_t;

endpackage

// File: rtl/capbank_dp.sv
module capbank_dp
  import capbank_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int Q_W        = 16,
  parameter int QG_W       = 16,
  parameter int PCT_W      = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic signed [Q_W-1:0]        qMeas,
  input  logic [NUM_GROUPS*QG_W-1:0]   groupKvar,
  input  logic [PCT_W-1:0]             setPct,
  input  logic [NUM_GROUPS-1:0]        groupEn,
  input  capStrobe_t                   strobe,
  output capStatus_t                   status,
  output logic [NUM_GROUPS-1:0]        contactor
);

  localparam int PROD_W = Q_W + QG_W + PCT_W + 4;
  localparam int DIFF_W = ((Q_W > QG_W) ? Q_W : QG_W) + 2;
  localparam logic signed [PROD_W-1:0] HUNDRED = 100;
  localparam logic signed [PROD_W-1:0] SIXTY   = 60;

  logic [NUM_GROUPS-1:0] state;

  // Threshold comparison on values scaled by 100, no divider needed
  logic signed [PROD_W-1:0] qExt, q1Ext, pctExt, qScaled, upperLim, lowerLim;

  assign qExt     = {{(PROD_W-Q_W){qMeas[Q_W-1]}}, qMeas};
  assign q1Ext    = {{(PROD_W-QG_W){1'b0}}, groupKvar[QG_W-1:0]};
  assign pctExt   = {{(PROD_W-PCT_W){1'b0}}, setPct};
  assign qScaled  = qExt * HUNDRED;
  assign upperLim = (pctExt + SIXTY) * q1Ext;
  assign lowerLim = (pctExt - SIXTY) * q1Ext;

  logic qPos, qNeg;
  assign qNeg = qMeas[Q_W-1];
  assign qPos = !qNeg && (qMeas != '0);

  // Fit distances for each group
  function automatic logic [DIFF_W-1:0] magOf(input logic signed [DIFF_W-1:0] v);
    return v[DIFF_W-1] ? DIFF_W'(-v) : DIFF_W'(v);
  endfunction

  logic signed [DIFF_W-1:0] qSx, qAbsX;
  assign qSx   = {{(DIFF_W-Q_W){qMeas[Q_W-1]}}, qMeas};
  assign qAbsX = qNeg ? -qSx : qSx;

  logic [DIFF_W-1:0]     dIn  [NUM_GROUPS];
  logic [DIFF_W-1:0]     dOut [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] candIn, candOut;

  for (genvar n = 0; n < NUM_GROUPS; n++) begin : g_fit
    logic signed [DIFF_W-1:0] gPow;
    assign gPow       = {{(DIFF_W-QG_W){1'b0}}, groupKvar[n*QG_W +: QG_W]};
    assign dIn[n]     = magOf(gPow - qSx);
    assign dOut[n]    = magOf(gPow - qAbsX);
    assign candIn[n]  = !state[n] && groupEn[n];
    assign candOut[n] = state[n] && groupEn[n];
  end

  // Linear minimum search; strict compare keeps the lowest index on ties
  logic [NUM_GROUPS-1:0] pickIn, pickOut;
  logic [DIFF_W-1:0]     bestIn, bestOut;
  logic                  foundIn, foundOut;

  always_comb begin
    pickIn   = '0;
    pickOut  = '0;
    bestIn   = '0;
    bestOut  = '0;
    foundIn  = 1'b0;
    foundOut = 1'b0;
    for (int n = 0; n < NUM_GROUPS; n++) begin
      if (candIn[n] && (!foundIn || dIn[n] < bestIn)) begin
        pickIn    = '0;
        pickIn[n] = 1'b1;
        bestIn    = dIn[n];
        foundIn   = 1'b1;
      end
      if (candOut[n] && (!foundOut || dOut[n] < bestOut)) begin
        pickOut    = '0;
        pickOut[n] = 1'b1;
        bestOut    = dOut[n];
        foundOut   = 1'b1;
      end
    end
  end

  assign status.wantIn  = qPos && (qScaled > upperLim);
  assign status.wantOut = qNeg && (qScaled < lowerLim);
  assign status.haveIn  = foundIn;
  assign status.haveOut = foundOut;

  // Contactor state; the enable mask is applied on every edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= '0;
    end else begin
      state <= (state | (strobe.switchIn ? pickIn : '0))
             & ~(strobe.switchOut ? pickOut : '0)
             & groupEn;
    end
  end

  assign contactor = state;

  // R6: at most one enabled group changes per edge
  a_r6_single_change: assert property (@(posedge clk) disable iff (!rstN)
    $countones((state ^ $past(state)) & $past(groupEn)) <= 1);

  // R8: nothing stays on whose enable was low at the previous edge
  a_r8_disabled_off: assert property (@(posedge clk) disable iff (!rstN)
    (state & ~$past(groupEn)) == '0);

  // R4: a connection strobe turns on exactly one previously-off group
  a_r4_one_added: assert property (@(posedge clk) disable iff (!rstN)
    strobe.switchIn |=> $countones(state & ~$past(state)) == 1);

  // R5: a release strobe leaves no new group connected
  a_r5_none_added: assert property (@(posedge clk) disable iff (!rstN)
    strobe.switchOut |=> (state & ~$past(state)) == '0);

endmodule

// File: rtl/capbank_ctl.sv
module capbank_ctl
  import capbank_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int TICK_DIV = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qValid,
  input  logic [DLY_W-1:0] holdTicks,
  input  capStatus_t       status,
  output capStrobe_t       strobe,
  output logic             satFlag
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] prescale;
  logic [DLY_W-1:0] holdCnt;
  logic             ready, evalNow, acted, tick;

  assign ready   = (holdCnt == '0);
  assign evalNow = qValid && ready;
  assign tick    = (prescale == DIV_LAST);

  assign strobe.switchIn  = evalNow && status.wantIn  && status.haveIn;
  assign strobe.switchOut = evalNow && status.wantOut && status.haveOut;
  assign strobe.setSat    = evalNow && ((status.wantIn  && !status.haveIn) ||
                                        (status.wantOut && !status.haveOut));
  assign strobe.clrSat    = evalNow && !strobe.setSat;
  assign acted            = strobe.switchIn || strobe.switchOut;

  // Prescaler realigns on every action so the wait is exact
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale <= '0;
      holdCnt  <= '0;
      satFlag  <= 1'b0;
    end else begin
      if (acted || tick) prescale <= '0;
      else               prescale <= prescale + 1'b1;

      if (acted)                       holdCnt <= holdTicks;
      else if (tick && holdCnt != '0)  holdCnt <= holdCnt - 1'b1;

      if (strobe.setSat)      satFlag <= 1'b1;
      else if (strobe.clrSat) satFlag <= 1'b0;
    end
  end

  // R7: a nonzero wait blocks evaluation on the edge after an action
  a_r7_hold_after_switch: assert property (@(posedge clk) disable iff (!rstN)
    (acted && holdTicks != '0) |=> !ready);

  // R9: the flag only rises from an evaluated sample
  a_r9_sat_from_eval: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> $past(qValid));

  // R10: without a valid strobe no action is taken
  a_r10_no_act_idle: assert property (@(posedge clk) disable iff (!rstN)
    !qValid |-> !acted);

endmodule

// File: rtl/capbank_switch_ctrl.sv
module capbank_switch_ctrl
  import capbank_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int Q_W        = 16,
  parameter int QG_W       = 16,
  parameter int PCT_W      = 8,
  parameter int DLY_W      = 16,
  parameter int TICK_DIV   = 1000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       qValid,
  input  logic signed [Q_W-1:0]      qMeas,
  input  logic [NUM_GROUPS*QG_W-1:0] groupKvar,
  input  logic [PCT_W-1:0]           setPct,
  input  logic [DLY_W-1:0]           holdTicks,
  input  logic [NUM_GROUPS-1:0]      groupEn,
  output logic [NUM_GROUPS-1:0]      contactor,
  output logic                       satFlag
);

  capStrobe_t strobe;
  capStatus_t status;

  capbank_dp #(
    .NUM_GROUPS(NUM_GROUPS), .Q_W(Q_W), .QG_W(QG_W), .PCT_W(PCT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .qMeas(qMeas), .groupKvar(groupKvar),
    .setPct(setPct), .groupEn(groupEn), .strobe(strobe),
    .status(status), .contactor(contactor)
  );

  capbank_ctl #(
    .DLY_W(DLY_W), .TICK_DIV(TICK_DIV)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .holdTicks(holdTicks),
    .status(status), .strobe(strobe), .satFlag(satFlag)
  );

  // R3: a sample inside the band only sees forced releases
  a_r3_in_band: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && !status.wantIn && !status.wantOut)
      |=> contactor == ($past(contactor) & $past(groupEn)));

  // R9: saturation is reported with the contactors held
  a_r9_sat_holds: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> contactor == ($past(contactor) & $past(groupEn)));

endmodule

// File: tb/capbank_switch_ctrl_bench.sv
module capbank_switch_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int NG         = 6;

  logic              clk = 1'b0;
  logic              rstN;
  logic              qValid;
  logic signed [15:0] qMeas;
  logic [NG*16-1:0]  groupKvar;
  logic [7:0]        setPct;
  logic [15:0]       holdTicks;
  logic [NG-1:0]     groupEn;
  logic [NG-1:0]     contactor;
  logic              satFlag;

  int gq [NG];
  always_comb for (int n = 0; n < NG; n++) groupKvar[n*16 +: 16] = gq[n][15:0];

  always #(CLK_PERIOD/2) clk = ~clk;

  capbank_switch_ctrl #(.TICK_DIV(TICK)) u_capbank_switch_ctrl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qMeas(qMeas),
    .groupKvar(groupKvar), .setPct(setPct), .holdTicks(holdTicks),
    .groupEn(groupEn), .contactor(contactor), .satFlag(satFlag)
  );

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 0;

  // bench model state
  logic [NG-1:0] mState;
  bit            mSat;
  int            mRem;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // One clock: drive a sample, predict, compare after the edge
  task automatic step(input bit v, input int q);
    int bi, bo, bd, d, pct, q1;
    bit wIn, wOut, rdy, acted, nsat;
    logic [NG-1:0] ns;
    string tg;
    qValid = v;
    qMeas  = q[15:0];
    pct = int'(setPct);
    q1  = gq[0];
    wIn  = (q > 0) && (q * 100 > (60 + pct) * q1);
    wOut = (q < 0) && (q * 100 < (pct - 60) * q1);
    rdy  = (mRem == 0);
    bi = -1; bd = 0;
    for (int n = 0; n < NG; n++) begin
      d = absi(q - gq[n]);
      if (!mState[n] && groupEn[n] && (bi < 0 || d < bd)) begin bi = n; bd = d; end
    end
    bo = -1; bd = 0;
    for (int n = 0; n < NG; n++) begin
      d = absi(absi(q) - gq[n]);
      if (mState[n] && groupEn[n] && (bo < 0 || d < bd)) begin bo = n; bd = d; end
    end
    ns = mState; nsat = mSat; acted = 0; tg = "R10";
    if (v && rdy) begin
      if (wIn) begin
        tg = "R4";
        if (bi >= 0) begin ns[bi] = 1'b1; acted = 1; nsat = 0; end
        else nsat = 1;
      end else if (wOut) begin
        tg = "R5";
        if (bo >= 0) begin ns[bo] = 1'b0; acted = 1; nsat = 0; end
        else nsat = 1;
      end else begin
        tg = "R3";
        nsat = 0;
      end
    end else if (v && !rdy) tg = "R7";
    if ((mState & ~groupEn) != 0) tg = "R8";
    ns = ns & groupEn;
    @(posedge clk);
    @(negedge clk);
    chk(tg, int'(contactor), int'(ns));
    chk("R9", int'(satFlag), int'(nsat));
    mState = ns; mSat = nsat;
    if (acted) mRem = int'(holdTicks) * TICK;
    else if (mRem > 0) mRem--;
  endtask

  task automatic setPowers(input int a, b, c, d, e, f);
    gq[0] = a; gq[1] = b; gq[2] = c; gq[3] = d; gq[4] = e; gq[5] = f;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1357));
    rstN = 0; qValid = 0; qMeas = 0; setPct = 0; holdTicks = 0; groupEn = '1;
    setPowers(100, 250, 400, 150, 300, 500);
    mState = '0; mSat = 0; mRem = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(contactor), 0);
    chk("R1", int'(satFlag), 0);
    rstN = 1;
    @(posedge clk); @(negedge clk);
    chk("R1", int'(contactor), 0);

    // R2 boundary: upper limit 60 at x=0, q1=100
    step(1, 60);  chk("R2", int'(contactor), 0);
    step(1, 61);  chk("R2", int'(contactor), 6'b000001);
    // R4 best fit picks group 3 for 420
    step(1, 420); chk("R4", int'(contactor), 6'b000101);
    // R2 lower boundary -60, then R5 release group 1
    step(1, -60); chk("R2", int'(contactor), 6'b000101);
    step(1, -61); chk("R5", int'(contactor), 6'b000100);
    // R10 non-valid strobe ignored
    step(0, 900); chk("R10", int'(contactor), 6'b000100);
    // R8 disable a connected group without a sample
    groupEn = 6'b111011;
    step(0, 0);   chk("R8", int'(contactor), 6'b000000);
    // R9 saturation with nothing connected, then cleared in band
    step(1, -500); chk("R9", int'(satFlag), 1);
    chk("R9", int'(contactor), 0);
    step(1, 0);    chk("R9", int'(satFlag), 0);
    // R4 tie: groups 2 and 3 equal, lowest index wins
    groupEn = '1;
    setPowers(100, 200, 200, 900, 900, 900);
    step(1, 200); chk("R4", int'(contactor), 6'b000010);
    // R7 wait window with hold of 2 ticks
    holdTicks = 2;
    step(1, 950); chk("R6", int'(contactor), 6'b001010);
    for (int k = 0; k < 2 * TICK; k++) step(1, 950);
    chk("R7", int'(contactor), 6'b001010);
    step(1, 950); chk("R7", int'(contactor), 6'b011010);

    // Random phase
    for (int it = 0; it < 4000; it++) begin
      if ($urandom_range(0, 59) == 0)
        setPowers($urandom_range(20, 1000), $urandom_range(20, 1000),
                  $urandom_range(20, 1000), $urandom_range(20, 1000),
                  $urandom_range(20, 1000), $urandom_range(20, 1000));
      if ($urandom_range(0, 99) == 0) setPct = 8'($urandom_range(0, 100));
      if ($urandom_range(0, 99) == 0) holdTicks = 16'($urandom_range(0, 3));
      if ($urandom_range(0, 29) == 0)
        groupEn = ($urandom_range(0, 1) == 1) ? '1 : 6'($urandom_range(0, 63));
      step($urandom_range(0, 1) == 1, int'($urandom_range(0, 6000)) - 3000);
    end
    finishRun();
  end

endmodule